// File: doc/BRIEF.md
# External Bus Cycle Strobe Generator

This block sits between an internal requester and an external 20-bit address, 16-bit data bus. It turns a byte or word read, fetch or write request into one or two external bus cycles. During each cycle it drives active-low write-enable, output-enable and two byte-lane enables. A request is accepted through a valid/ready handshake, and completion is signalled by a one-clock done pulse that carries the assembled read data.

One input pin has two roles. While reset is held, it selects the width of the boot bus. After reset, it is the wait input that stretches the strobe-active phase of a cycle. Each request picks either the latched boot width or an explicit per-request width, as supplied by the chip-select decode outside this block. On an 8-bit bus, a word access is split into two byte cycles.

Top module: `ebus_strobe_gen`

## Requirements
- R1: While `rstN` is low, `waitSize` is sampled on every clock. The value held at the last reset clock sets the boot width (1 = 16-bit, 0 = 8-bit). `bootBus16` shows this width and stays unchanged until the next reset.
- R2: Outside reset, `waitSize` = 1 at a rising edge inside a strobe-active clock extends that cycle by one clock, with address and strobes held. `waitSize` has no effect while the block is idle or in the clock between cycles.
- R3: `weN` is low only during the active clocks of a write cycle (`reqKind` = 2'b10). `oeN` is low only during the active clocks of a read cycle (`reqKind` 2'b00 read, 2'b01 fetch, 2'b11 also read). The two are never low together.
- R4: `bleN` is low on every cycle that uses data lines 7..0. These are every 8-bit-bus cycle, every 16-bit read or fetch, every 16-bit word write, and every 16-bit byte write to an even address.
- R5: `bheN` is never low during a cycle on an 8-bit bus.
- R6: On a 16-bit bus, `bheN` is low on every read or fetch, whether byte or word, and on every word write. A 16-bit byte write asserts only the lane given by address bit 0 (0 = low lane, 1 = high lane).
- R7: During each cycle, `busAddr` shows the request address captured at acceptance. For word requests, address bit 0 of the request is ignored and forced to 0.
- R8: A word request on an 8-bit bus runs as two byte cycles: the even address first, then address+1. The strobes are high for exactly one clock between the two cycles.
- R9: `reqReady` is high only when the block is idle and out of reset. A request is taken when `reqValid` and `reqReady` are both high at a rising edge, and the strobes go active in the next clock. Each cycle has at least one active clock, and all strobes are high in the clock after each cycle.
- R10: `rspDone` is high for exactly one clock: the clock after the final active clock of a request. `rspRdata` is then built from `busDin` sampled on the last active clock. The rules are: a 16-bit word takes both lanes; a 16-bit byte takes the lane given by address bit 0 into bits 7..0; an 8-bit byte takes lines 7..0; a split word places its first byte in bits 7..0 and its second byte in bits 15..8. All unused upper bits are 0.
- R11: For writes, `busDout` carries the data on the lanes in use. A 16-bit word carries all 16 bits. A 16-bit byte carries `reqWdata[7:0]` copied onto both lanes. An 8-bit bus carries the current byte on lines 7..0 (low byte first for a word) and 0 on lines 15..8.
- R12: When `reqBootSel` = 1, the cycle width is the latched boot width; otherwise it is `reqBus16`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| waitSize | input | 1 | Boot width during reset, wait afterwards |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Block idle, request can be taken |
| reqKind | input | 2 | 00 read, 01 fetch, 10 write, 11 read |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqBootSel | input | 1 | Use latched boot width for this request |
| reqBus16 | input | 1 | Width when not boot: 1 = 16-bit |
| reqAddr | input | 20 | Request byte address |
| reqWdata | input | 16 | Write data |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdata | output | 16 | Read data, valid with rspDone |
| busAddr | output | 20 | External address |
| busDout | output | 16 | External write data |
| busDin | input | 16 | External read data |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| bleN | output | 1 | Low byte lane enable, active low |
| bheN | output | 1 | High byte lane enable, active low |
| bootBus16 | output | 1 | Latched boot width |

## Verification
Wait release and read-data capture act on the same rising edge. In a split word, that edge also decides between returning to idle and starting the second byte cycle. The bench drives a fresh random value on `busDin` in every active clock and holds wait high for a random number of clocks in each half. The read result must therefore match the byte present in the last active clock of each half, and nothing earlier. Wait is also held high during idle and between-cycle clocks; the cycle-by-cycle model then requires the strobes to stay high and acceptance to go ahead unchanged.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } ebusState_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'b00,
    KIND_FETCH = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_RSVD  = 2'b11
  } ebusKind_e;

  // control to datapath strobes
  typedef struct packed {
    logic load;     // request taken this clock
    logic active;   // strobe-active clock
    logic capture;  // last active clock (wait low)
    logic half;     // second byte cycle of a split word
  } ebusCtl_t;

endpackage

// File: rtl/ebus_ctrl.sv
module ebus_ctrl
  import ebus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     waitIn,
  input  logic     splitWord,
  output logic     reqReady,
  output logic     rspDone,
  output ebusCtl_t ctl
);

  ebusState_e state;
  logic       halfQ;
  logic       doneQ;

  always_comb begin
    reqReady    = (state == ST_IDLE) && rstN;
    ctl.load    = reqReady && reqValid;
    ctl.active  = (state == ST_ACTIVE);
    ctl.capture = (state == ST_ACTIVE) && !waitIn;
    ctl.half    = halfQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      halfQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= ctl.capture && (!splitWord || halfQ);
      case (state)
        ST_IDLE: begin
          if (ctl.load) begin
            state <= ST_ACTIVE;
            halfQ <= 1'b0;
          end
        end
        ST_ACTIVE: begin
          if (!waitIn) state <= ST_GAP;
        end
        ST_GAP: begin
          if (splitWord && !halfQ) begin
            state <= ST_ACTIVE;
            halfQ <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rspDone = doneQ;

endmodule

// File: rtl/ebus_dpath.sv
module ebus_dpath
  import ebus_pkg::*;
#(
  parameter int AddrW = 20,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             waitSize,
  input  ebusCtl_t         ctl,
  input  logic [1:0]       reqKind,
  input  logic             reqWord,
  input  logic             reqBootSel,
  input  logic             reqBus16,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqWdata,
  input  logic [DataW-1:0] busDin,
  output logic [AddrW-1:0] busAddr,
  output logic [DataW-1:0] busDout,
  output logic             weN,
  output logic             oeN,
  output logic             bleN,
  output logic             bheN,
  output logic [DataW-1:0] rspRdata,
  output logic             splitWord,
  output logic             bootBus16,
  output logic             curBus16
);

  localparam int ByteW = DataW / 2;

  logic             bootQ;
  logic             wrQ;
  logic             wordQ;
  logic             bus16Q;
  logic [AddrW-1:0] addrQ;
  logic [DataW-1:0] wdataQ;
  logic [DataW-1:0] rdataQ;

  logic [ByteW-1:0] dinLo;
  logic [ByteW-1:0] dinHi;
  logic [ByteW-1:0] wLo;
  logic [ByteW-1:0] wHi;
  logic             lowUse;
  logic             highUse;

  // boot width: sampled on every reset clock, held afterwards
  always_ff @(posedge clk) begin
    if (!rstN) bootQ <= waitSize;
  end

  // request capture at acceptance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ    <= 1'b0;
      wordQ  <= 1'b0;
      bus16Q <= 1'b0;
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (ctl.load) begin
      wrQ    <= (reqKind == KIND_WRITE);
      wordQ  <= reqWord;
      bus16Q <= reqBootSel ? bootQ : reqBus16;
      addrQ  <= reqWord ? {reqAddr[AddrW-1:1], 1'b0} : reqAddr;
      wdataQ <= reqWdata;
    end
  end

  assign dinLo = busDin[ByteW-1:0];
  assign dinHi = busDin[DataW-1:ByteW];
  assign wLo   = wdataQ[ByteW-1:0];
  assign wHi   = wdataQ[DataW-1:ByteW];

  // read data assembly on the last active clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (ctl.capture && !wrQ) begin
      if (bus16Q) begin
        if (wordQ)         rdataQ <= busDin;
        else if (addrQ[0]) rdataQ <= {{ByteW{1'b0}}, dinHi};
        else               rdataQ <= {{ByteW{1'b0}}, dinLo};
      end else if (wordQ && ctl.half) begin
        rdataQ[DataW-1:ByteW] <= dinLo;
      end else begin
        rdataQ <= {{ByteW{1'b0}}, dinLo};
      end
    end
  end

  // lane usage
  always_comb begin
    lowUse  = !bus16Q || !wrQ || wordQ || !addrQ[0];
    highUse = bus16Q && (!wrQ || wordQ || addrQ[0]);
  end

  always_comb begin
    weN  = !(ctl.active && wrQ);
    oeN  = !(ctl.active && !wrQ);
    bleN = !(ctl.active && lowUse);
    bheN = !(ctl.active && highUse);
  end

  // address: second half of a split word selects the odd byte
  assign busAddr = {addrQ[AddrW-1:1], addrQ[0] | ctl.half};

  always_comb begin
    if (bus16Q) busDout = wordQ ? wdataQ : {wLo, wLo};
    else        busDout = {{ByteW{1'b0}}, (ctl.half ? wHi : wLo)};
  end

  assign rspRdata  = rdataQ;
  assign splitWord = wordQ && !bus16Q;
  assign bootBus16 = bootQ;
  assign curBus16  = bus16Q;

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
  import ebus_pkg::*;
#(
  parameter int AddrW = 20,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             waitSize,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqKind,
  input  logic             reqWord,
  input  logic             reqBootSel,
  input  logic             reqBus16,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [DataW-1:0] reqWdata,
  output logic             rspDone,
  output logic [DataW-1:0] rspRdata,
  output logic [AddrW-1:0] busAddr,
  output logic [DataW-1:0] busDout,
  input  logic [DataW-1:0] busDin,
  output logic             weN,
  output logic             oeN,
  output logic             bleN,
  output logic             bheN,
  output logic             bootBus16
);

  ebusCtl_t ctl;
  logic     splitWord;
  logic     curBus16;

  ebus_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .waitIn    (waitSize),
    .splitWord (splitWord),
    .reqReady  (reqReady),
    .rspDone   (rspDone),
    .ctl       (ctl)
  );

  ebus_dpath #(.AddrW(AddrW), .DataW(DataW)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .waitSize   (waitSize),
    .ctl        (ctl),
    .reqKind    (reqKind),
    .reqWord    (reqWord),
    .reqBootSel (reqBootSel),
    .reqBus16   (reqBus16),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busDin     (busDin),
    .busAddr    (busAddr),
    .busDout    (busDout),
    .weN        (weN),
    .oeN        (oeN),
    .bleN       (bleN),
    .bheN       (bheN),
    .rspRdata   (rspRdata),
    .splitWord  (splitWord),
    .bootBus16  (bootBus16),
    .curBus16   (curBus16)
  );

endmodule

// File: rtl/ebus_strobe_gen_chk.sv
module ebus_strobe_gen_chk #(
  parameter int AddrW = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             waitSize,
  input logic             reqReady,
  input logic             rspDone,
  input logic [AddrW-1:0] busAddr,
  input logic             weN,
  input logic             oeN,
  input logic             bleN,
  input logic             bheN,
  input logic             bootBus16,
  input logic             curBus16
);

  logic strobeOn;
  assign strobeOn = !weN || !oeN;

  p_boot_latch_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (bootBus16 == $past(waitSize)));

  p_boot_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(bootBus16));

  p_wait_stretch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && waitSize) |=> (strobeOn && $stable(busAddr) && $stable(weN)));

  p_we_oe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !oeN));

  p_ble_bus8_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !curBus16) |-> !bleN);

  p_bhe_bus8_r5: assert property (@(posedge clk) disable iff (!rstN)
    !bheN |-> curBus16);

  p_bhe_read16_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!oeN && curBus16) |-> !bheN);

  p_gap_after_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !waitSize) |=> (weN && oeN && bleN && bheN));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (weN && oeN && bleN && bheN));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

endmodule

bind ebus_strobe_gen ebus_strobe_gen_chk #(.AddrW(AddrW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .waitSize  (waitSize),
  .reqReady  (reqReady),
  .rspDone   (rspDone),
  .busAddr   (busAddr),
  .weN       (weN),
  .oeN       (oeN),
  .bleN      (bleN),
  .bheN      (bheN),
  .bootBus16 (bootBus16),
  .curBus16  (curBus16)
);

// File: tb/ebus_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ebus_strobe_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        waitSize = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = 2'b00;
  logic        reqWord = 1'b0;
  logic        reqBootSel = 1'b0;
  logic        reqBus16 = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspDone;
  logic [15:0] rspRdata;
  logic [19:0] busAddr;
  logic [15:0] busDout;
  logic [15:0] busDin = '0;
  logic        weN, oeN, bleN, bheN;
  logic        bootBus16;

  int  tests = 0;
  int  fails = 0;
  bit  finished = 1'b0;
  bit  bootKnown = 1'b0;

  always #4 clk = ~clk;

  ebus_strobe_gen dut_i (
    .clk(clk), .rstN(rstN), .waitSize(waitSize), .reqValid(reqValid),
    .reqReady(reqReady), .reqKind(reqKind), .reqWord(reqWord),
    .reqBootSel(reqBootSel), .reqBus16(reqBus16), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspDone(rspDone), .rspRdata(rspRdata),
    .busAddr(busAddr), .busDout(busDout), .busDin(busDin), .weN(weN),
    .oeN(oeN), .bleN(bleN), .bheN(bheN), .bootBus16(bootBus16)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkIdleStrobes(input string tag);
    chk(tag, {28'h0, weN, oeN, bleN, bheN}, 32'hF);
  endtask

  task automatic doReset(input logic bootVal);
    @(negedge clk);
    rstN = 1'b0;
    waitSize = ~bootVal;
    @(negedge clk);
    chkIdleStrobes("R9 strobes high in reset");
    chk("R9 ready low in reset", {31'h0, reqReady}, 32'h0);
    waitSize = bootVal;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    waitSize = 1'b0;
    bootKnown = bootVal;
    @(negedge clk);
    chk("R1 boot width latched", {31'h0, bootBus16}, {31'h0, bootVal});
    chk("R9 ready in idle", {31'h0, reqReady}, 32'h1);
  endtask

  // cycle-by-cycle reference walk of one request
  task automatic txn(input logic [1:0] kind, input logic word, input logic bootSel,
                     input logic bus16, input logic [19:0] addr, input logic [15:0] wd,
                     input int w0, input int w1);
    logic        isWr, eff16, split, expBle, expBhe;
    logic [15:0] dLast[2];
    logic [15:0] expDout, expRd;
    logic [19:0] expAddr;
    int          halves;
    isWr   = (kind == 2'b10);
    eff16  = bootSel ? bootKnown : bus16;
    split  = word && !eff16;
    halves = split ? 2 : 1;
    chk("R9 ready before request", {31'h0, reqReady}, 32'h1);
    reqValid = 1'b1; reqKind = kind; reqWord = word; reqBootSel = bootSel;
    reqBus16 = bus16; reqAddr = addr; reqWdata = wd;
    waitSize = 1'b1;  // ignored while idle (R2)
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~addr; reqWdata = ~wd; reqBus16 = ~bus16;
    for (int h = 0; h < halves; h++) begin
      int waits;
      waits = (h == 0) ? w0 : w1;
      expAddr = word ? {addr[19:1], (h == 1)} : addr;
      expBle  = !eff16 || !isWr || word || !addr[0];
      expBhe  = eff16 && (!isWr || word || addr[0]);
      if (eff16) expDout = word ? wd : {wd[7:0], wd[7:0]};
      else       expDout = {8'h00, (h == 1) ? wd[15:8] : wd[7:0]};
      for (int c = 0; c <= waits; c++) begin
        chk("R3 weN", {31'h0, weN}, {31'h0, !isWr});
        chk("R3 oeN", {31'h0, oeN}, {31'h0, isWr});
        chk("R4 bleN", {31'h0, bleN}, {31'h0, !expBle});
        chk("R5 R6 bheN", {31'h0, bheN}, {31'h0, !expBhe});
        chk("R7 R8 busAddr", {12'h0, busAddr}, {12'h0, expAddr});
        if (isWr) chk("R11 busDout", {16'h0, busDout}, {16'h0, expDout});
        busDin = 16'($urandom);
        dLast[h] = busDin;
        waitSize = (c < waits);
        @(negedge clk);
      end
      chkIdleStrobes("R8 R9 gap after cycle");
      waitSize = 1'b1;  // ignored between cycles (R2)
      if (h == halves - 1) begin
        chk("R10 done pulse", {31'h0, rspDone}, 32'h1);
        if (!isWr) begin
          if (eff16 && word)  expRd = dLast[0];
          else if (eff16)     expRd = {8'h00, addr[0] ? dLast[0][15:8] : dLast[0][7:0]};
          else if (word)      expRd = {dLast[1][7:0], dLast[0][7:0]};
          else                expRd = {8'h00, dLast[0][7:0]};
          chk("R10 R12 read data", {16'h0, rspRdata}, {16'h0, expRd});
        end
      end else begin
        chk("R10 no early done", {31'h0, rspDone}, 32'h0);
      end
      @(negedge clk);
    end
    chk("R10 done is one clock", {31'h0, rspDone}, 32'h0);
    chkIdleStrobes("R2 wait ignored in idle");
    waitSize = 1'b0;
  endtask

  initial begin
    doReset(1'b1);
    txn(2'b00, 1'b1, 1'b1, 1'b0, 20'h12344, 16'h0, 0, 0);   // R12 boot 16-bit word read
    txn(2'b01, 1'b0, 1'b1, 1'b0, 20'h00105, 16'h0, 1, 0);   // R6 odd byte fetch
    txn(2'b10, 1'b0, 1'b0, 1'b1, 20'h0A0A2, 16'h5A3C, 0, 0); // R6 even byte write
    txn(2'b10, 1'b0, 1'b0, 1'b1, 20'h0A0A3, 16'h5A3C, 2, 0); // R6 odd byte write
    txn(2'b10, 1'b1, 1'b0, 1'b1, 20'hFFFFF, 16'hBEEF, 3, 0); // R7 word odd addr ignored
    txn(2'b00, 1'b0, 1'b0, 1'b1, 20'h00007, 16'h0, 0, 0);   // R10 odd byte read 16
    txn(2'b00, 1'b1, 1'b0, 1'b0, 20'h40000, 16'h0, 2, 3);   // R8 split read
    txn(2'b10, 1'b1, 1'b0, 1'b0, 20'h40011, 16'hC0DE, 0, 1); // R8 R11 split write
    txn(2'b11, 1'b0, 1'b0, 1'b0, 20'h00003, 16'h0, 0, 0);   // R3 kind 11 reads
    doReset(1'b0);
    txn(2'b00, 1'b1, 1'b1, 1'b1, 20'h80002, 16'h0, 1, 1);   // R1 R12 boot 8-bit split
    txn(2'b10, 1'b0, 1'b1, 1'b1, 20'h80003, 16'h00A5, 0, 0); // R5 boot 8-bit byte write
    for (int i = 0; i < 60; i++) begin
      txn(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom),
          16'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      if (i == 30) doReset(1'($urandom));
    end
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule